// File: doc/BRIEF.md
# SD Host Data Transfer Sequencer

This block runs the control side of one data transfer on an SD host. Software programs a byte length and a control word with three bits: enable, direction and read-wait-start. A control write that has enable set, made while the block is idle, starts a transfer. On that cycle the block copies the length into its down-counter. It then parks in a send-wait or receive-wait state until the serializer reports that data movement has begun. If read-wait-start was set, it parks in a read-wait state instead.

While the block is active, the serializer stub sends one pulse per byte moved. Each pulse takes one off the counter. When the count reaches zero, the block goes back to idle and sets a sticky data-end flag. Software clears that flag through a separate clear strobe. The counter can be read at any time through the count output. Writes aimed at it are accepted on the port and then dropped. Separate busy outputs show whether a receive or a transmit sequence owns the data lines.

Top module: `sdpath_data_seq`

## Requirements
- R1: A control write (`ctl_wr`=1) with `ctl_en`=1 and `ctl_rdwait`=0, made while idle, moves `state_o` to send-wait (code 1) on the next cycle when `ctl_dir`=0, and to receive-wait (code 3) when `ctl_dir`=1. Idle is code 0.
- R2: The same start with `ctl_rdwait`=1 enters read-wait (code 5), whatever `ctl_dir` is. In read-wait, `byte_done` pulses are ignored. A later control write with `ctl_rdwait`=0 moves the block to receive-wait on the next cycle.
- R3: `cnt_o` takes the value of `ctl_len` on the same edge that leaves idle. Control writes made while not idle never reload it.
- R4: In send-wait or receive-wait, a `ser_start` pulse moves the block to send-active (code 2) or receive-active (code 4). Each `byte_done` in an active state lowers `cnt_o` by exactly one. `byte_done` in idle or in a wait state changes nothing.
- R5: The `byte_done` that takes the count from 1 to 0 returns the block to idle and sets `done_o` on the same edge. A transfer started with length 0 returns from its wait state to idle, with `done_o` set, one cycle after entering it.
- R6: Holding `ctl_en` high without a new control write never starts another transfer. Only a fresh `ctl_wr` with `ctl_en`=1 does.
- R7: A write to the counter (`cnt_wr`, `cnt_wdata`) never changes `cnt_o`, in any state.
- R8: `rx_busy_o` is high exactly in codes 3, 4 and 5. `tx_busy_o` is high exactly in codes 1 and 2. The two are never high together.
- R9: `done_o` stays set until `done_clr` is pulsed. If the clear and a new completion fall on the same edge, the flag ends up set.
- R10: While `rst` is high at a clock edge, the block returns to idle with `cnt_o`=0 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Transfer enable bit of the written control word |
| ctl_dir | input | 1 | Direction bit: 0 host-to-card, 1 card-to-host |
| ctl_rdwait | input | 1 | Start the transfer in read-wait |
| ctl_len | input | CNT_W | Programmed transfer length in bytes |
| cnt_wr | input | 1 | Write strobe aimed at the counter (ignored) |
| cnt_wdata | input | CNT_W | Data of the ignored counter write |
| ser_start | input | 1 | Serializer reports that data movement began |
| byte_done | input | 1 | Serializer pulse, one per byte moved |
| done_clr | input | 1 | Clears the data-end flag |
| state_o | output | 3 | Sequencer state code |
| rx_busy_o | output | 1 | Receive sequence in progress |
| tx_busy_o | output | 1 | Transmit sequence in progress |
| cnt_o | output | CNT_W | Bytes remaining |
| done_o | output | 1 | Sticky data-end flag |

## Verification
The hardest cases to reach from the ports are inputs that arrive in the wrong state. These are stray byte pulses in read-wait and in the wait states, restart attempts while a transfer runs, and a flag clear that lands on the edge that completes a transfer. The bench sweeps lengths 0 to 9 in both directions, with and without read-wait. Inside each transfer it injects these stray inputs at fixed points and checks that the counter and state do not move. It also lines the final byte pulse up with a clear pulse to exercise the set-over-clear rule.

// File: rtl/sdpath_pkg.sv
package sdpath_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_WAIT_S = 3'd1,
    SQ_SEND   = 3'd2,
    SQ_WAIT_R = 3'd3,
    SQ_RECV   = 3'd4,
    SQ_RDWAIT = 3'd5
  } sq_state_t;

  function automatic logic sq_is_rx(input sq_state_t s);
    return (s == SQ_WAIT_R) || (s == SQ_RECV) || (s == SQ_RDWAIT);
  endfunction

  function automatic logic sq_is_tx(input sq_state_t s);
    return (s == SQ_WAIT_S) || (s == SQ_SEND);
  endfunction

  function automatic logic sq_is_active(input sq_state_t s);
    return (s == SQ_SEND) || (s == SQ_RECV);
  endfunction

  function automatic logic sq_is_wait(input sq_state_t s);
    return (s == SQ_WAIT_S) || (s == SQ_WAIT_R);
  endfunction

endpackage

// File: rtl/sdpath_ctl_decode.sv
module sdpath_ctl_decode
  import sdpath_pkg::*;
(
  input  sq_state_t state,
  input  logic      ctl_wr,
  input  logic      ctl_en,
  input  logic      ctl_rdwait,
  output logic      start_evt,
  output logic      release_evt
);
  // a start needs an explicit write; a held enable level does nothing
  assign start_evt   = ctl_wr && ctl_en && (state == SQ_IDLE);
  assign release_evt = ctl_wr && !ctl_rdwait && (state == SQ_RDWAIT);
endmodule

// File: rtl/sdpath_counter.sv
module sdpath_counter #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_evt,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero,
  output logic             cnt_one
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load_evt) cnt <= load_val;
    else if (dec_evt)  cnt <= step_down(cnt);
  end

  assign cnt_zero = (cnt == '0);
  assign cnt_one  = (cnt == ONE);
endmodule

// File: rtl/sdpath_fsm.sv
module sdpath_fsm
  import sdpath_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_evt,
  input  logic      release_evt,
  input  logic      ctl_dir,
  input  logic      ctl_rdwait,
  input  logic      ser_start,
  input  logic      end_evt,
  output sq_state_t state
);
  sq_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      SQ_IDLE:
        if (start_evt) begin
          if (ctl_rdwait)   nxt = SQ_RDWAIT;
          else if (ctl_dir) nxt = SQ_WAIT_R;
          else              nxt = SQ_WAIT_S;
        end
      SQ_WAIT_S:
        if (end_evt)        nxt = SQ_IDLE;
        else if (ser_start) nxt = SQ_SEND;
      SQ_WAIT_R:
        if (end_evt)        nxt = SQ_IDLE;
        else if (ser_start) nxt = SQ_RECV;
      SQ_SEND, SQ_RECV:
        if (end_evt)        nxt = SQ_IDLE;
      SQ_RDWAIT:
        if (release_evt)    nxt = SQ_WAIT_R;
      default:              nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SQ_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/sdpath_data_seq.sv
module sdpath_data_seq
  import sdpath_pkg::*;
#(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_dir,
  input  logic             ctl_rdwait,
  input  logic [CNT_W-1:0] ctl_len,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ser_start,
  input  logic             byte_done,
  input  logic             done_clr,
  output logic [2:0]       state_o,
  output logic             rx_busy_o,
  output logic             tx_busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  sq_state_t state;
  logic start_evt, release_evt, dec_evt, last_evt, empty_evt, end_evt;
  logic cnt_zero, cnt_one;
  logic [CNT_W-1:0] cnt;
  logic done_q;

  // the counter is read-only: its write port is accepted and dropped
  logic unused_cnt_write;
  assign unused_cnt_write = ^{cnt_wr, cnt_wdata};

  sdpath_ctl_decode u_dec (
    .state(state), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_rdwait(ctl_rdwait),
    .start_evt(start_evt), .release_evt(release_evt)
  );

  assign dec_evt   = byte_done && sq_is_active(state);
  assign last_evt  = dec_evt && cnt_one;
  assign empty_evt = sq_is_wait(state) && cnt_zero;
  assign end_evt   = last_evt || empty_evt;

  sdpath_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_evt(start_evt), .load_val(ctl_len),
    .dec_evt(dec_evt), .cnt(cnt), .cnt_zero(cnt_zero), .cnt_one(cnt_one)
  );

  sdpath_fsm u_fsm (
    .clk(clk), .rst(rst), .start_evt(start_evt), .release_evt(release_evt),
    .ctl_dir(ctl_dir), .ctl_rdwait(ctl_rdwait), .ser_start(ser_start),
    .end_evt(end_evt), .state(state)
  );

  // completion wins over a clear on the same edge
  always_ff @(posedge clk) begin
    if (rst)           done_q <= 1'b0;
    else if (end_evt)  done_q <= 1'b1;
    else if (done_clr) done_q <= 1'b0;
  end

  assign state_o   = state;
  assign rx_busy_o = sq_is_rx(state);
  assign tx_busy_o = sq_is_tx(state);
  assign cnt_o     = cnt;
  assign done_o    = done_q;
endmodule

// File: rtl/sdpath_data_seq_chk.sv
module sdpath_data_seq_chk #(
  parameter int CNT_W = 25
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic             ctl_en,
  input logic             ctl_dir,
  input logic             ctl_rdwait,
  input logic [CNT_W-1:0] ctl_len,
  input logic             byte_done,
  input logic             done_clr,
  input logic [2:0]       state_o,
  input logic             rx_busy_o,
  input logic             tx_busy_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic go;
  assign go = ctl_wr && ctl_en && (state_o == 3'd0);

  a_r1_start_dir: assert property (@(posedge clk) disable iff (rst)
    (go && !ctl_rdwait) |=> (state_o == ($past(ctl_dir) ? 3'd3 : 3'd1)));

  a_r2_rdwait_entry: assert property (@(posedge clk) disable iff (rst)
    (go && ctl_rdwait) |=> (state_o == 3'd5));

  a_r2_rdwait_holds: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd5 && !ctl_wr) |=> (state_o == 3'd5) && $stable(cnt_o));

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    go |=> (cnt_o == $past(ctl_len)));

  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 3'd2 || state_o == 3'd4) && byte_done && cnt_o > ONE)
      |=> (cnt_o == $past(cnt_o) - ONE));

  a_r5_last_byte: assert property (@(posedge clk) disable iff (rst)
    ((state_o == 3'd2 || state_o == 3'd4) && byte_done && cnt_o == ONE)
      |=> (state_o == 3'd0) && done_o && (cnt_o == '0));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && !go) |=> (state_o == 3'd0) && $stable(cnt_o));

  a_r8_busy_excl: assert property (@(posedge clk) disable iff (rst)
    !(rx_busy_o && tx_busy_o));

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_o && !done_clr) |=> done_o);

  a_r10_reset: assert property (@(posedge clk)
    rst |=> (state_o == 3'd0) && (cnt_o == '0) && !done_o);
endmodule

bind sdpath_data_seq sdpath_data_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_dir(ctl_dir),
  .ctl_rdwait(ctl_rdwait), .ctl_len(ctl_len), .byte_done(byte_done),
  .done_clr(done_clr), .state_o(state_o), .rx_busy_o(rx_busy_o),
  .tx_busy_o(tx_busy_o), .cnt_o(cnt_o), .done_o(done_o)
);

// File: tb/test_sdpath_data_seq.sv
module test_sdpath_data_seq;
  localparam int CNT_W = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, ctl_en = 0, ctl_dir = 0, ctl_rdwait = 0;
  logic [CNT_W-1:0] ctl_len = '0;
  logic cnt_wr = 0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic ser_start = 0, byte_done = 0, done_clr = 0;
  logic [2:0] state_o;
  logic rx_busy_o, tx_busy_o, done_o;
  logic [CNT_W-1:0] cnt_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  sdpath_data_seq #(.CNT_W(CNT_W)) i_sdpath_data_seq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected busy flags computed from the state code
  task automatic chk_busy(input logic [2:0] code);
    chk("R8 rx_busy", rx_busy_o, (code == 3 || code == 4 || code == 5));
    chk("R8 tx_busy", tx_busy_o, (code == 1 || code == 2));
  endtask

  // every drive happens at a falling edge; results are read one edge later
  task automatic step;
    @(negedge clk);
    ctl_wr = 0; cnt_wr = 0; ser_start = 0; byte_done = 0; done_clr = 0;
  endtask

  task automatic run_xfer(input logic dir, input logic rdw, input int len);
    logic [2:0] wait_code, act_code;
    int remaining;
    wait_code = dir ? 3'd3 : 3'd1;
    act_code  = dir ? 3'd4 : 3'd2;
    remaining = len;
    ctl_wr = 1; ctl_en = 1; ctl_dir = dir; ctl_rdwait = rdw; ctl_len = CNT_W'(len);
    step();
    chk("R3 load", cnt_o, len);
    if (rdw) begin
      chk("R2 rdwait state", state_o, 5);
      chk_busy(3'd5);
      byte_done = 1; step();
      chk("R2 pulse ignored", cnt_o, len);
      chk("R2 still rdwait", state_o, 5);
      ctl_wr = 1; ctl_en = 1; ctl_rdwait = 0; ctl_len = CNT_W'(len + 7); step();
      chk("R2 release", state_o, 3);
      chk("R3 no reload", cnt_o, len);
      wait_code = 3'd3; act_code = 3'd4;
    end else begin
      chk("R1 wait state", state_o, wait_code);
    end
    chk_busy(wait_code);
    if (len == 0) begin
      step();
      chk("R5 zero length idle", state_o, 0);
      chk("R5 zero length flag", done_o, 1);
    end else begin
      byte_done = 1; step();
      chk("R4 wait ignores pulse", cnt_o, len);
      ser_start = 1; step();
      chk("R4 active", state_o, act_code);
      chk_busy(act_code);
      while (remaining > 0) begin
        if (remaining == 2) begin
          cnt_wr = 1; cnt_wdata = CNT_W'(99); step();
          chk("R7 counter write ignored", cnt_o, remaining);
          ctl_wr = 1; ctl_en = 1; ctl_len = CNT_W'(55); step();
          chk("R3 busy write no reload", cnt_o, remaining);
        end
        byte_done = 1;
        if (remaining == 1) done_clr = 1;
        step();
        remaining--;
        chk("R4 decrement", cnt_o, remaining);
        step();
        chk("R4 gap holds", cnt_o, remaining);
      end
      chk("R5 end idle", state_o, 0);
      chk("R9 set wins over clear", done_o, 1);
    end
    step(); step();
    chk("R6 level enable no restart", state_o, 0);
    chk("R9 sticky", done_o, 1);
    byte_done = 1; step();
    chk("R4 idle ignores pulse", cnt_o, 0);
    done_clr = 1; step();
    chk("R9 cleared", done_o, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R10 reset state", state_o, 0);
        chk("R10 reset count", cnt_o, 0);
        chk("R10 reset flag", done_o, 0);
        rst = 0;
        step();
        for (int rdw = 0; rdw < 2; rdw++)
          for (int dir = 0; dir < 2; dir++)
            for (int len = 0; len < 10; len++)
              run_xfer(dir[0], rdw[0], len);
        // reset in the middle of a transfer
        ctl_wr = 1; ctl_en = 1; ctl_dir = 0; ctl_rdwait = 0; ctl_len = CNT_W'(5); step();
        rst = 1; step(); rst = 0;
        chk("R10 mid reset state", state_o, 0);
        chk("R10 mid reset count", cnt_o, 0);
      end
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule